// File: doc/BRIEF.md
# Banked Internal Data RAM

A 256-byte on-chip scratch memory for a small 8-bit processor core. The memory array can be reached through three ports, and each port gives a different view of it. A working-register port takes a register number from 0 to 7 and finds the byte inside the bank that the two bank-select bits name. The bank-select bits are copied from bits 4 and 3 of the status word. There are four banks of eight registers, and they sit at the bottom 32 bytes. A byte port takes an 8-bit address with a mode flag, either direct or indirect. Direct mode can reach only the lower 128 bytes. Indirect mode reaches all 256.

A bit port reads, sets or clears one bit. The 128 bits live in the sixteen bytes starting at 20H, and the bit port reaches them by bit number. A set or clear is a read-modify-write. It captures the byte in the request cycle and writes it back in the following cycle, and a busy flag is high for that second cycle. The array has a single access slot per cycle, so a fixed priority settles any conflict between ports. Reset clears the output registers and the pending state but never clears the memory contents.

Top module: `banked_data_ram`

## Requirements
- R1: A register-port access to register n (regNum) with bank-select value k (bankSel; bankSel[1] is status bit 4, bankSel[0] is status bit 3) touches byte k*8+n. A read shows that byte on regRdata one clock after the request edge. A write stores regWdata at the request edge.
- R2: Byte-port mode is chosen by byteIndirect, where 0 means direct and 1 means indirect. Indirect mode accepts any address from 00H to FFH. Direct mode accepts 00H to 7FH. A served read shows the byte on byteRdata one clock after the request edge.
- R3: A direct-mode byte request with byteAddr of 80H or above is not served. For the following cycle, byteMiss is 1 and byteRdata is 00H. A write with such an address changes nothing.
- R4: A bit address b below 80H selects bit (b & 7) of byte 20H + (b >> 3). A bit read returns that bit on bitRdata one clock after the request.
- R5: The bitOp encoding is 00 for read, 01 for set, 10 for clear, and 11, which acts as read. A set or clear returns the bit's old value on bitRdata and raises bitBusy for exactly the next cycle. It writes the byte at the end of that cycle and changes no other bit of it.
- R6: A bit address of 80H or above is not served. For the following cycle, bitMiss is 1 and bitRdata is 0. The memory does not change and bitBusy stays 0.
- R7: Only one access is served per cycle. While bitBusy is 1, every request is ignored. Otherwise the bit port wins over the register port, and the register port wins over the byte port. A request that loses is dropped.
- R8: Reset forces regRdata, byteRdata, bitRdata, byteMiss, bitMiss and bitBusy to 0. It leaves every memory byte as it was.
- R9: Bytes 80H to FFH hold data that is separate from bytes 00H to 7FH. The byte port can reach them only in indirect mode.

Misses and unserved requests leave the read-data outputs holding their last values, except where R3 and R6 say otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bankSel | input | 2 | Bank-select bits copied from status bits 4:3 |
| regEn | input | 1 | Register-port request |
| regWe | input | 1 | Register-port write (1) or read (0) |
| regNum | input | 3 | Working register number 0..7 |
| regWdata | input | 8 | Register-port write data |
| regRdata | output | 8 | Register-port read data |
| byteEn | input | 1 | Byte-port request |
| byteWe | input | 1 | Byte-port write (1) or read (0) |
| byteIndirect | input | 1 | 1 = indirect mode, 0 = direct mode |
| byteAddr | input | 8 | Byte address |
| byteWdata | input | 8 | Byte-port write data |
| byteRdata | output | 8 | Byte-port read data |
| byteMiss | output | 1 | Direct request above 7FH was not served |
| bitEn | input | 1 | Bit-port request |
| bitOp | input | 2 | 00 read, 01 set, 10 clear, 11 read |
| bitAddr | input | 8 | Bit address |
| bitRdata | output | 1 | Bit read value, or the old value on set/clear |
| bitMiss | output | 1 | Bit address above 7FH was not served |
| bitBusy | output | 1 | Write-back cycle of a bit set/clear |

## Verification
The bench builds the block with its default parameters: 8-bit data, 8-bit addresses, two bank-select bits, three register-number bits, and the bit area based at 20H. With these values the whole 256-byte array can be filled and checked through the indirect port. Both ends of the bit window are within reach (bit 00H and bit 7FH), and so is the direct-mode boundary at 7FH/80H. Every bank-select value is used. The bench drives conflicting requests in the same cycle, and it also sends requests while a read-modify-write is still in flight.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  // Strobes from the control unit to the datapath, one slot per cycle
  typedef struct packed {
    logic rdReg;     // register-port read of addr
    logic rdByte;    // byte-port read of addr
    logic rdBit;     // bit read of addr/bitPos (also on set/clear)
    logic missByte;  // direct byte request out of range
    logic missBit;   // bit address out of range
    logic wrEn;      // plain byte write of wdata into addr
    logic capture;   // latch addressed byte for read-modify-write
    logic commit;    // write back modified byte
  } strobe_t;

  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [1:0] OP_SET   = 2'b01;
  localparam logic [1:0] OP_CLEAR = 2'b10;
endpackage

// File: rtl/bdr_ctrl.sv
module bdr_ctrl
  import bdr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int BANK_W   = 2,
  parameter int REG_W    = 3,
  parameter int BIT_BASE = 32,
  parameter int BIT_BYTES = 16,
  localparam int POS_W   = $clog2(DATA_W),
  localparam int BIT_SPAN = BIT_BYTES * DATA_W,
  localparam int DIRECT_LIMIT = 1 << (ADDR_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              regEn,
  input  logic              regWe,
  input  logic [REG_W-1:0]  regNum,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              byteEn,
  input  logic              byteWe,
  input  logic              byteIndirect,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [DATA_W-1:0] byteWdata,
  input  logic              bitEn,
  input  logic [1:0]        bitOp,
  input  logic [ADDR_W-1:0] bitAddr,
  output strobe_t           strobe,
  output logic [ADDR_W-1:0] accAddr,
  output logic [DATA_W-1:0] accWdata,
  output logic [POS_W-1:0]  accPos,
  output logic              accSetVal,
  output logic              busy
);
  logic              pend;
  logic [ADDR_W-1:0] pendAddr;
  logic [POS_W-1:0]  pendPos;
  logic              pendVal;

  logic              bitInRange;
  logic              byteInRange;
  logic              bitWrite;
  logic [ADDR_W-1:0] bitByteAddr;
  logic [ADDR_W-1:0] regAddr;

  always_comb begin
    bitInRange  = int'(bitAddr) < BIT_SPAN;
    byteInRange = byteIndirect || (int'(byteAddr) < DIRECT_LIMIT);
    bitWrite    = (bitOp == OP_SET) || (bitOp == OP_CLEAR);
    bitByteAddr = ADDR_W'(BIT_BASE) + ADDR_W'(bitAddr >> POS_W);
    regAddr     = ADDR_W'({bankSel, regNum});
  end

  always_comb begin
    strobe    = '0;
    accAddr   = '0;
    accWdata  = '0;
    accPos    = '0;
    accSetVal = 1'b0;
    if (pend) begin
      strobe.commit = 1'b1;
      accAddr   = pendAddr;
      accPos    = pendPos;
      accSetVal = pendVal;
    end else if (bitEn) begin
      if (bitInRange) begin
        strobe.rdBit   = 1'b1;
        strobe.capture = bitWrite;
        accAddr   = bitByteAddr;
        accPos    = bitAddr[POS_W-1:0];
        accSetVal = (bitOp == OP_SET);
      end else begin
        strobe.missBit = 1'b1;
      end
    end else if (regEn) begin
      accAddr  = regAddr;
      accWdata = regWdata;
      strobe.wrEn  = regWe;
      strobe.rdReg = !regWe;
    end else if (byteEn) begin
      if (byteInRange) begin
        accAddr  = byteAddr;
        accWdata = byteWdata;
        strobe.wrEn   = byteWe;
        strobe.rdByte = !byteWe;
      end else begin
        strobe.missByte = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pendAddr <= '0;
      pendPos  <= '0;
      pendVal  <= 1'b0;
    end else begin
      pend <= strobe.capture;
      if (strobe.capture) begin
        pendAddr <= accAddr;
        pendPos  <= accPos;
        pendVal  <= accSetVal;
      end
    end
  end

  assign busy = pend;

  // R7
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(strobe.wrEn || strobe.rdReg || strobe.rdByte || strobe.rdBit || strobe.capture));

  // R5
  rmw_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> (busy && strobe.commit));

  // R5
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R1
  reg_in_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.rdReg || (regEn && regWe && !bitEn && !busy)) |->
      (int'(accAddr) < (1 << (BANK_W + REG_W)) && accAddr[REG_W +: BANK_W] == bankSel));

  // R7
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.commit, strobe.rdBit, strobe.missBit, strobe.rdReg,
              strobe.rdByte, strobe.missByte, strobe.wrEn && !regEn, strobe.wrEn && regEn}));
endmodule

// File: rtl/bdr_datapath.sv
module bdr_datapath
  import bdr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  localparam int POS_W = $clog2(DATA_W),
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWdata,
  input  logic [POS_W-1:0]  accPos,
  input  logic              accSetVal,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] byteRdata,
  output logic              byteMiss,
  output logic              bitRdata,
  output logic              bitMiss
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rmwByte;
  logic [DATA_W-1:0] rmwNext;
  logic [DATA_W-1:0] rdWord;

  assign rdWord = mem[accAddr];

  // Replace only the selected bit of the captured byte
  for (genvar i = 0; i < DATA_W; i++) begin : g_merge
    assign rmwNext[i] = (accPos == POS_W'(i)) ? accSetVal : rmwByte[i];
  end

  // Memory array: no reset, contents survive reset
  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      mem[accAddr] <= accWdata;
    end else if (strobe.commit) begin
      mem[accAddr] <= rmwNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      rmwByte <= rdWord;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regRdata  <= '0;
      byteRdata <= '0;
      byteMiss  <= 1'b0;
      bitRdata  <= 1'b0;
      bitMiss   <= 1'b0;
    end else begin
      byteMiss <= strobe.missByte;
      bitMiss  <= strobe.missBit;
      if (strobe.rdReg) begin
        regRdata <= rdWord;
      end
      if (strobe.rdByte) begin
        byteRdata <= rdWord;
      end else if (strobe.missByte) begin
        byteRdata <= '0;
      end
      if (strobe.rdBit) begin
        bitRdata <= rdWord[accPos];
      end else if (strobe.missBit) begin
        bitRdata <= 1'b0;
      end
    end
  end

  // R3
  miss_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.missByte |-> !(strobe.wrEn || strobe.commit));

  // R3
  miss_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byteMiss |-> (byteRdata == '0));

  // R5
  rmw_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |=> ($countones(mem[$past(accAddr)] ^ $past(rmwByte)) <= 1));

  // R6
  bit_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitMiss |-> !bitRdata);
endmodule

// File: rtl/banked_data_ram.sv
module banked_data_ram
  import bdr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int BANK_W    = 2,
  parameter int REG_W     = 3,
  parameter int BIT_BASE  = 32,
  parameter int BIT_BYTES = 16,
  localparam int POS_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              regEn,
  input  logic              regWe,
  input  logic [REG_W-1:0]  regNum,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              byteEn,
  input  logic              byteWe,
  input  logic              byteIndirect,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [DATA_W-1:0] byteWdata,
  output logic [DATA_W-1:0] byteRdata,
  output logic              byteMiss,
  input  logic              bitEn,
  input  logic [1:0]        bitOp,
  input  logic [ADDR_W-1:0] bitAddr,
  output logic              bitRdata,
  output logic              bitMiss,
  output logic              bitBusy
);
  strobe_t           strobe;
  logic [ADDR_W-1:0] accAddr;
  logic [DATA_W-1:0] accWdata;
  logic [POS_W-1:0]  accPos;
  logic              accSetVal;

  bdr_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W),
    .BIT_BASE(BIT_BASE), .BIT_BYTES(BIT_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bankSel(bankSel),
    .regEn(regEn), .regWe(regWe), .regNum(regNum), .regWdata(regWdata),
    .byteEn(byteEn), .byteWe(byteWe), .byteIndirect(byteIndirect),
    .byteAddr(byteAddr), .byteWdata(byteWdata),
    .bitEn(bitEn), .bitOp(bitOp), .bitAddr(bitAddr),
    .strobe(strobe), .accAddr(accAddr), .accWdata(accWdata),
    .accPos(accPos), .accSetVal(accSetVal), .busy(bitBusy)
  );

  bdr_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .accAddr(accAddr), .accWdata(accWdata), .accPos(accPos), .accSetVal(accSetVal),
    .regRdata(regRdata), .byteRdata(byteRdata), .byteMiss(byteMiss),
    .bitRdata(bitRdata), .bitMiss(bitMiss)
  );
endmodule

// File: tb/sim_banked_data_ram.sv
module sim_banked_data_ram;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bankSel = '0;
  logic       regEn = 0, regWe = 0;
  logic [2:0] regNum = '0;
  logic [7:0] regWdata = '0;
  logic       byteEn = 0, byteWe = 0, byteIndirect = 0;
  logic [7:0] byteAddr = '0, byteWdata = '0;
  logic       bitEn = 0;
  logic [1:0] bitOp = '0;
  logic [7:0] bitAddr = '0;
  logic [7:0] regRdata, byteRdata;
  logic       byteMiss, bitRdata, bitMiss, bitBusy;

  int checks = 0;
  int failures = 0;
  bit cmpOn = 0;
  bit finished = 0;

  banked_data_ram u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29 + 7) & 255);
  endfunction

  // Behavioural reference model, advanced on every rising edge
  logic [7:0] mm [256];
  logic [7:0] eReg = 0, eByte = 0;
  logic       eBit = 0, eByteMiss = 0, eBitMiss = 0, eBusy = 0;
  bit         mPend = 0;
  int         mA, mP;
  bit         mVal;

  always @(posedge clk) begin
    if (!rst_n) begin
      eReg = 0; eByte = 0; eBit = 0; eByteMiss = 0; eBitMiss = 0; eBusy = 0; mPend = 0;
    end else begin
      eByteMiss = 0; eBitMiss = 0;
      if (mPend) begin
        mm[mA][mP] = mVal;
        mPend = 0;
      end else if (bitEn) begin
        if (bitAddr >= 128) begin
          eBitMiss = 1; eBit = 0;
        end else begin
          int a, p;
          a = 32 + bitAddr / 8;
          p = bitAddr % 8;
          eBit = mm[a][p];
          if (bitOp == 2'b01 || bitOp == 2'b10) begin
            mPend = 1; mA = a; mP = p; mVal = (bitOp == 2'b01);
          end
        end
      end else if (regEn) begin
        int a;
        a = bankSel * 8 + regNum;
        if (regWe) mm[a] = regWdata; else eReg = mm[a];
      end else if (byteEn) begin
        if (!byteIndirect && byteAddr >= 128) begin
          eByteMiss = 1; eByte = 0;
        end else if (byteWe) mm[byteAddr] = byteWdata;
        else eByte = mm[byteAddr];
      end
      eBusy = mPend;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare with the model on every falling edge
  always @(negedge clk) begin
    if (cmpOn && rst_n) begin
      chk(regRdata, eReg, "R1 model regRdata");
      chk(byteRdata, eByte, "R2 model byteRdata");
      chk({7'd0, byteMiss}, {7'd0, eByteMiss}, "R3 model byteMiss");
      chk({7'd0, bitRdata}, {7'd0, eBit}, "R4 model bitRdata");
      chk({7'd0, bitMiss}, {7'd0, eBitMiss}, "R6 model bitMiss");
      chk({7'd0, bitBusy}, {7'd0, eBusy}, "R5 model bitBusy");
    end
  end

  task automatic tick();
    @(negedge clk);
    regEn = 0; byteEn = 0; bitEn = 0; regWe = 0; byteWe = 0;
  endtask

  task automatic byteOp(input bit we, input bit ind, input int a, input logic [7:0] d);
    byteEn = 1; byteWe = we; byteIndirect = ind; byteAddr = 8'(a); byteWdata = d;
    tick();
  endtask

  task automatic regOp(input bit we, input int bank, input int n, input logic [7:0] d);
    regEn = 1; regWe = we; bankSel = 2'(bank); regNum = 3'(n); regWdata = d;
    tick();
  endtask

  task automatic bitOpDo(input logic [1:0] op, input int b);
    bitEn = 1; bitOp = op; bitAddr = 8'(b);
    tick();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mm[i] = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(regRdata, 8'h00, "R8 reset regRdata");
    chk(byteRdata, 8'h00, "R8 reset byteRdata");
    chk({5'd0, byteMiss, bitMiss, bitBusy}, 8'h00, "R8 reset flags");
    rst_n = 1;
    @(negedge clk);
    cmpOn = 1;

    // Fill every byte indirectly (R9)
    for (int a = 0; a < 256; a++) byteOp(1, 1, a, pat(a));

    // R2 direct and indirect reads
    byteOp(0, 0, 8'h00, 0); chk(byteRdata, pat(8'h00), "R2 direct 00H");
    byteOp(0, 0, 8'h35, 0); chk(byteRdata, pat(8'h35), "R2 direct 35H");
    byteOp(0, 0, 8'h7F, 0); chk(byteRdata, pat(8'h7F), "R2 direct 7FH");
    byteOp(0, 1, 8'h42, 0); chk(byteRdata, pat(8'h42), "R2 indirect 42H");
    // R9 upper half
    byteOp(0, 1, 8'h80, 0); chk(byteRdata, pat(8'h80), "R9 indirect 80H");
    byteOp(0, 1, 8'hFF, 0); chk(byteRdata, pat(8'hFF), "R9 indirect FFH");

    // R3 direct above 7FH
    byteOp(0, 0, 8'h90, 0);
    chk(byteRdata, 8'h00, "R3 miss data");
    chk({7'd0, byteMiss}, 8'h01, "R3 miss flag");
    byteOp(1, 0, 8'h90, 8'hAA);
    byteOp(0, 1, 8'h90, 0); chk(byteRdata, pat(8'h90), "R3 direct write ignored");
    chk({7'd0, byteMiss}, 8'h00, "R3 flag clears");

    // R1 register port in each bank
    for (int k = 0; k < 4; k++) begin
      regOp(1, k, k + 2, 8'hC0 + 8'(k));
      byteOp(0, 0, k * 8 + k + 2, 0);
      chk(byteRdata, 8'hC0 + 8'(k), "R1 reg write lands in bank");
    end
    regOp(0, 2, 5, 0); chk(regRdata, pat(8'h15), "R1 bank2 R5 read");
    regOp(0, 3, 7, 0); chk(regRdata, pat(8'h1F), "R1 bank3 R7 read");

    // R4 bit reads at both ends of the window
    bitOpDo(2'b00, 8'h0B); chk({7'd0, bitRdata}, {7'd0, pat(8'h21)[3]}, "R4 bit 0BH");
    bitOpDo(2'b00, 8'h7F); chk({7'd0, bitRdata}, {7'd0, pat(8'h2F)[7]}, "R4 bit 7FH");
    bitOpDo(2'b11, 8'h00); chk({7'd0, bitRdata}, {7'd0, pat(8'h20)[0]}, "R5 op 11 reads");

    // R5 set and clear
    bitOpDo(2'b01, 8'h13);
    chk({7'd0, bitRdata}, {7'd0, pat(8'h22)[3]}, "R5 set returns old bit");
    chk({7'd0, bitBusy}, 8'h01, "R5 busy in write-back cycle");
    tick();
    chk({7'd0, bitBusy}, 8'h00, "R5 busy one cycle");
    byteOp(0, 0, 8'h22, 0); chk(byteRdata, pat(8'h22) | 8'h08, "R5 set only one bit");
    bitOpDo(2'b10, 8'h7F); tick();
    byteOp(0, 0, 8'h2F, 0); chk(byteRdata, pat(8'h2F) & 8'h7F, "R5 clear only one bit");

    // R7 request during busy is dropped
    bitOpDo(2'b01, 8'h28);
    byteOp(1, 1, 8'h40, 8'h55);
    byteOp(0, 1, 8'h40, 0); chk(byteRdata, pat(8'h40), "R7 write during busy ignored");
    byteOp(0, 1, 8'h25, 0); chk(byteRdata, pat(8'h25) | 8'h01, "R5 set 28H landed");

    // R6 out-of-range bit address
    bitOpDo(2'b00, 8'h85);
    chk({7'd0, bitMiss}, 8'h01, "R6 miss flag");
    chk({7'd0, bitRdata}, 8'h00, "R6 miss data");
    bitOpDo(2'b01, 8'h90);
    chk({7'd0, bitBusy}, 8'h00, "R6 no busy on miss");
    byteOp(0, 1, 8'h32, 0); chk(byteRdata, pat(8'h32), "R6 memory unchanged");

    // R7 priority: bit > reg > byte
    bitEn = 1; bitOp = 2'b00; bitAddr = 8'h01;
    regEn = 1; regWe = 1; bankSel = 0; regNum = 7; regWdata = 8'h11;
    byteEn = 1; byteWe = 1; byteIndirect = 1; byteAddr = 8'h50; byteWdata = 8'h22;
    tick();
    chk({7'd0, bitRdata}, {7'd0, pat(8'h20)[1]}, "R7 bit port wins");
    byteOp(0, 0, 8'h07, 0); chk(byteRdata, pat(8'h07), "R7 reg write dropped");
    byteOp(0, 0, 8'h50, 0); chk(byteRdata, pat(8'h50), "R7 byte write dropped");
    regEn = 1; regWe = 1; bankSel = 1; regNum = 6; regWdata = 8'h33;
    byteEn = 1; byteWe = 1; byteIndirect = 1; byteAddr = 8'h51; byteWdata = 8'h44;
    tick();
    byteOp(0, 0, 8'h0E, 0); chk(byteRdata, 8'h33, "R7 reg port wins");
    byteOp(0, 0, 8'h51, 0); chk(byteRdata, pat(8'h51), "R7 byte loses to reg");

    // R8 reset keeps memory
    byteOp(1, 1, 8'hA0, 8'h5A);
    cmpOn = 0;
    rst_n = 0;
    @(negedge clk);
    chk(byteRdata, 8'h00, "R8 reset clears byteRdata");
    chk(regRdata, 8'h00, "R8 reset clears regRdata");
    rst_n = 1;
    @(negedge clk);
    mPend = 0;
    cmpOn = 1;
    byteOp(0, 1, 8'hA0, 0); chk(byteRdata, 8'h5A, "R8 memory survives reset");
    byteOp(0, 0, 8'h0E, 0); chk(byteRdata, 8'h33, "R8 register survives reset");

    finished = 1;
    finish_run();
  end
endmodule